// File: doc/BRIEF.md
# Pipelined Histogram Sorter

The block orders the 256 counts of a byte histogram so that code construction for an entropy coder can walk them from rarest to most frequent. Counts arrive one per cycle on a valid/ready stream. The symbol of each count is its position in the stream. The block returns the same 256 entries as (count, symbol) pairs in ascending order. A single-cycle marker flags the final pair of each histogram.

Inside, eight lanes each put a 32-entry slice in order with five merge passes of 32 cycles each. Three merge stages then join the slices: four mergers for 64 cycles, then two mergers for 128 cycles, then one merger for 256 cycles. Every stage hands its result to the next through a two-bank buffer. A later histogram can therefore enter while up to three earlier ones are still moving through the pipeline. The lane count must make log2(N/LANES) odd, so that the final slice pass lands in the first merge buffer.

Top module: `hist_sorter`

## Requirements
- R1: The k-th entry accepted for a histogram (k from 0 to N-1, idle cycles not counted) is given symbol k. Gaps in `in_valid` do not shift the symbol numbering.
- R2: Output pairs are in ascending count order. Pairs with equal counts are in ascending symbol order.
- R3: Each histogram yields exactly N output pairs on consecutive cycles. `out_last` is high with the N-th pair only.
- R4: Across one histogram's output, every symbol appears exactly once, paired with the count it was given on input.
- R5: A histogram's final pair is registered on the 608th rising edge after the edge that accepted its final entry (160 + 64 + 128 + 256 cycles).
- R6: Histograms may be streamed with no idle cycles between them. `in_ready` stays high, the final entries of consecutive histograms are accepted N edges apart, and R5 holds for each histogram.
- R7: After reset, `in_ready` is high and `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input count is offered |
| in_count | input | CW | Count of the next symbol in order |
| in_ready | output | 1 | Input bank has room; the entry is taken when both valid and ready are high |
| out_valid | output | 1 | A sorted pair is on the output |
| out_count | output | CW | Count of the sorted pair |
| out_sym | output | log2(N) | Symbol of the sorted pair |
| out_last | output | 1 | High with the final pair of a histogram |

## Verification
The bench uses the defaults: N = 256, LANES = 8 and CW = 16. These values give five slice passes and three merge stages, so the exact 608-cycle latency and the overlap of several histograms are both observable. Some histograms draw counts from a range of four or sixteen values. Others are all zero or all at the maximum count. These fill every merger with ties, so the symbol tie-break decides most comparisons. Six histograms are streamed back to back, which keeps every stage busy at once and exercises the bank swaps.

// File: rtl/hist_sorter.sv
module hist_sorter #(
  parameter int N     = 256,
  parameter int LANES = 8,
  parameter int CW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [CW-1:0]        in_count,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [CW-1:0]        out_count,
  output logic [$clog2(N)-1:0] out_sym,
  output logic                 out_last
);
  localparam int AW  = $clog2(N);
  localparam int EW  = CW + AW;
  localparam int RUN = N / LANES;
  localparam int RW  = $clog2(RUN);
  localparam int MS  = $clog2(LANES);
  localparam int NST = MS + 1;
  localparam int TW  = $clog2(RUN * RW + N);

  logic [EW-1:0] mem [NST][2][N];
  logic [1:0]    full [NST];
  logic [NST-1:0] wp, rp, busy, go, act, fin;
  logic [TW-1:0] cnt [NST];
  logic [TW-1:0] idx [NST];
  logic [EW-1:0] wdat [NST][LANES];
  logic [AW-1:0] wadr [NST][LANES];
  logic [AW-1:0] icnt;
  logic          p_even;

  assign in_ready = !full[0][wp[0]];

  for (genvar s = 0; s < NST; s++) begin : g_st
    localparam int SEG = RUN << s;
    localparam int T   = (s == 0) ? RUN * RW : SEG;
    localparam int NL  = LANES >> s;
    logic [AW-1:0] step, w;

    if (s == MS) begin : g_end
      assign go[s] = !busy[s] && full[s][rp[s]];
    end else begin : g_mid
      assign go[s] = !busy[s] && full[s][rp[s]] && !full[s+1][wp[s+1]];
    end
    assign act[s] = busy[s] | go[s];
    assign idx[s] = busy[s] ? cnt[s] : '0;
    assign fin[s] = act[s] && (idx[s] == TW'(T - 1));

    if (s == 0) begin : g_pass
      logic [TW-1:0] pass;
      assign pass   = idx[s] >> RW;
      assign step   = AW'(idx[s] & TW'(RUN - 1));
      assign w      = AW'(1) << pass;
      assign p_even = !pass[0];
    end else begin : g_one
      assign step = AW'(idx[s]);
      assign w    = AW'(SEG / 2);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_ln
      if (l < NL) begin : g_on
        localparam logic [AW-1:0] BASE = AW'(l * SEG);
        logic [AW-1:0] iq, jq, ie, je, pos, blk, la, ra, mask;
        logic [EW-1:0] lw, rw;
        logic          tl;
        assign mask = (w << 1) - AW'(1);
        assign pos  = step & mask;
        assign blk  = BASE + (step & ~mask);
        assign ie   = (pos == '0) ? '0 : iq;
        assign je   = (pos == '0) ? '0 : jq;
        assign la   = blk + ie;
        assign ra   = blk + w + je;
        if (s == 0) begin : g_rd0
          assign lw = p_even ? mem[0][rp[0]][la] : mem[1][wp[1]][la];
          assign rw = p_even ? mem[0][rp[0]][ra] : mem[1][wp[1]][ra];
        end else begin : g_rdn
          assign lw = mem[s][rp[s]][la];
          assign rw = mem[s][rp[s]][ra];
        end
        assign tl = (ie < w) && ((je >= w) || (lw <= rw));
        assign wdat[s][l] = tl ? lw : rw;
        assign wadr[s][l] = BASE + step;
        always_ff @(posedge clk) begin
          if (act[s]) begin
            iq <= ie + AW'(tl);
            jq <= je + AW'(!tl);
          end
        end
      end else begin : g_off
        assign wdat[s][l] = '0;
        assign wadr[s][l] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt <= '0;
      wp   <= '0;
      rp   <= '0;
      busy <= '0;
      for (int b = 0; b < NST; b++) begin
        full[b] <= '0;
        cnt[b]  <= '0;
      end
    end else begin
      if (in_valid && in_ready) begin
        icnt <= icnt + 1'b1;
        if (icnt == AW'(N - 1)) begin
          full[0][wp[0]] <= 1'b1;
          wp[0]          <= !wp[0];
        end
      end
      for (int s = 0; s < NST; s++) begin
        if (act[s]) begin
          busy[s] <= !fin[s];
          cnt[s]  <= idx[s] + 1'b1;
        end
        if (fin[s]) begin
          full[s][rp[s]] <= 1'b0;
          rp[s]          <= !rp[s];
        end
      end
      for (int s = 0; s < MS; s++) begin
        if (fin[s]) begin
          full[s+1][wp[s+1]] <= 1'b1;
          wp[s+1]            <= !wp[s+1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) mem[0][wp[0]][icnt] <= {in_count, icnt};
    if (act[0]) begin
      for (int l = 0; l < LANES; l++) begin
        if (p_even) mem[1][wp[1]][wadr[0][l]] <= wdat[0][l];
        else        mem[0][rp[0]][wadr[0][l]] <= wdat[0][l];
      end
    end
    for (int s = 1; s < MS; s++) begin
      if (act[s]) begin
        for (int l = 0; l < (LANES >> s); l++) mem[s+1][wp[s+1]][wadr[s][l]] <= wdat[s][l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_count <= '0;
      out_sym   <= '0;
    end else begin
      out_valid <= act[MS];
      out_last  <= fin[MS];
      if (act[MS]) {out_count, out_sym} <= wdat[MS][0];
    end
  end

  logic [AW-1:0] ocnt;
  always_ff @(posedge clk) begin
    if (rst) ocnt <= '0;
    else if (out_valid) ocnt <= ocnt + 1'b1;
  end

  a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(out_valid) && !$past(out_last) |-> {out_count, out_sym} > $past({out_count, out_sym}));
  a_r3_last_is_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  a_r3_no_gap: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |=> out_valid);
  a_r3_last_position: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_last == (ocnt == AW'(N - 1))));
  a_r6_no_stall: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> in_ready);
endmodule

// File: tb/hist_sorter_tb.sv
module hist_sorter_tb;
  localparam int N = 256, CW = 16, NH = 9, LAT = 608;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [CW-1:0] in_count = '0;
  logic in_ready, out_valid, out_last;
  logic [CW-1:0] out_count;
  logic [7:0] out_sym;

  hist_sorter u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_count(in_count),
    .in_ready(in_ready), .out_valid(out_valid), .out_count(out_count), .out_sym(out_sym),
    .out_last(out_last));

  always #5 clk = ~clk;

  logic [CW-1:0]   hc [NH][N];
  logic [CW+7:0]   ek [NH][N];
  int last_acc [NH];
  int cyc = 0, checks = 0, errors = 0, oh = 0, ok = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void build(int h);
    logic [CW+7:0] t;
    for (int k = 0; k < N; k++) ek[h][k] = {hc[h][k], 8'(k)};
    for (int a = 1; a < N; a++) begin
      t = ek[h][a];
      for (int b = a; b > 0; b--) begin
        if (ek[h][b-1] > t) begin
          ek[h][b] = ek[h][b-1];
          ek[h][b-1] = t;
        end
      end
    end
  endfunction

  task automatic send(int h, bit gaps);
    bit r;
    for (int k = 0; k < N; k++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        in_valid = 1'b0;
        repeat (g) @(negedge clk);
      end
      in_valid = 1'b1;
      in_count = hc[h][k];
      do begin
        r = in_ready;
        @(negedge clk);
      end while (!r);
    end
    last_acc[h] = cyc;
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (oh >= NH) begin
        checks++; errors++;
        $display("FAIL R3 extra output: got %h expected none", {out_count, out_sym});
      end else begin
        checks++;
        if ({out_count, out_sym} !== ek[oh][ok]) begin
          errors++;
          $display("FAIL R1 R2 R4 hist %0d pos %0d: got %h expected %h", oh, ok, {out_count, out_sym}, ek[oh][ok]);
        end
        checks++;
        if (out_last !== (ok == N-1)) begin
          errors++;
          $display("FAIL R3 hist %0d pos %0d: got last %0b expected %0b", oh, ok, out_last, ok == N-1);
        end
        if (ok == N-1) begin
          checks++;
          if (cyc - last_acc[oh] != LAT) begin
            errors++;
            $display("FAIL R5 hist %0d: got latency %0d expected %0d", oh, cyc - last_acc[oh], LAT);
          end
          oh++; ok = 0;
        end else ok++;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < N; k++) begin
      hc[0][k] = '0;
      hc[1][k] = CW'(255 - k);
      hc[2][k] = '1;
      hc[3][k] = CW'($urandom);
      hc[4][k] = CW'($urandom_range(0, 3));
      hc[5][k] = (k == 100) ? CW'(5) : '0;
      hc[6][k] = CW'(k);
      hc[7][k] = CW'($urandom_range(0, 15));
      hc[8][k] = CW'($urandom);
    end
    for (int h = 0; h < NH; h++) build(h);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0 || out_last !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset: got ready %0b valid %0b last %0b expected 1 0 0", in_ready, out_valid, out_last);
    end
    for (int h = 0; h < 3; h++) send(h, 1'b1);
    repeat (20) @(negedge clk);
    for (int h = 3; h < NH; h++) send(h, 1'b0);
    for (int h = 4; h < NH; h++) begin
      checks++;
      if (last_acc[h] - last_acc[h-1] != N) begin
        errors++;
        $display("FAIL R6 hist %0d: got spacing %0d expected %0d", h, last_acc[h] - last_acc[h-1], N);
      end
    end
    wait (oh == NH);
    repeat (10) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d histograms expected %0d", oh, NH);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule